// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Timer Compare

This block decides, every cycle, whether the hart should take an interrupt now and which one. It holds a small set of pending and enable bits for machine-level and supervisor-level software and timer sources. It combines them with the current privilege level and the global interrupt-enable flag. A flag that reports a nonzero host message joins the machine-level sources. When an eligible source exists, `take_o` is high and `cause_o` carries the cause word. The interrupt flag sits in the most significant bit and the source code sits in the low bits.

A comparator watches the free-running real-time count and raises the machine timer-pending bit once the count reaches the programmed compare value. Loading a new compare value clears that bit again. Register writes arrive as single-cycle strobes with a shared data word. An inter-processor interrupt strobe raises machine software-pending. The trap entry sequence that follows a take is handled elsewhere.

Top module: `irq_arbiter_top`

## Requirements
- R1: After synchronous reset, all pending and enable bits are clear and the compare value is all ones. With the host flag low, `take_o` is 0 and `cause_o` is 0.
- R2: Privilege is encoded user=0, supervisor=1, machine=3. Machine-level sources (machine soft, machine timer, host message) are eligible when privilege is below 3, or when it is 3 and `ie_i` is 1.
- R3: Supervisor-level sources (supervisor soft, supervisor timer) are eligible when privilege is 0, or when it is 1 and `ie_i` is 1.
- R4: Among eligible sources, machine soft beats machine timer, which beats host message, which beats every supervisor source.
- R5: Supervisor soft beats supervisor timer.
- R6: A soft or timer source counts only when its pending bit and its enable bit are both 1. The host source needs only `host_nz_i`. With no such source, `take_o` is 0.
- R7: Machine timer-pending is set on the clock edge where `rtc_i` is greater than or equal to the stored compare value. It then stays set until the compare value is written.
- R8: A compare write loads `wr_data_i` as the compare value and clears machine timer-pending on that edge. The comparison against the new value starts on the following edge.
- R9: A pending write updates supervisor soft from data bit 1, machine soft from bit 3 and supervisor timer from bit 5. Bit 7 (machine timer) is ignored.
- R10: An enable write loads supervisor soft from data bit 1, machine soft from bit 3, supervisor timer from bit 5 and machine timer from bit 7.
- R11: While `take_o` is 1, `cause_o` has bit XLEN-1 set and holds code soft=0, timer=1 or host=2 in its low bits. While `take_o` is 0, `cause_o` is 0.
- R12: `ipi_i` sets machine soft-pending on the next edge, even when a pending write in the same cycle clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_i | input | TIME_W | Real-time count |
| priv_i | input | 2 | Current privilege level |
| ie_i | input | 1 | Global interrupt enable for the current level |
| wr_pend_i | input | 1 | Write strobe, pending register |
| wr_enab_i | input | 1 | Write strobe, enable register |
| wr_cmp_i | input | 1 | Write strobe, compare register |
| wr_data_i | input | XLEN | Write data shared by the three strobes |
| ipi_i | input | 1 | Inter-processor interrupt strobe |
| host_nz_i | input | 1 | Host message register is nonzero |
| take_o | output | 1 | An interrupt is to be taken now |
| cause_o | output | XLEN | Cause word of the chosen interrupt |

## Verification
The hardest cases to reach from the ports involve collisions on a single edge. One is a compare write landing while the count already exceeds both the old and the new value. Another is an IPI strobe coinciding with a pending write that clears the same bit. Directed sequences produce these collisions on purpose. A long randomized phase follows. In that phase the count moves slowly and compare values are chosen close to it, so equality edges, rewrites and privilege changes occur many times. A behavioural model tracks every cycle, and its expected outputs are compared against the design in every cycle.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        CODE_SOFT  = 2'd0,
        CODE_TIMER = 2'd1,
        CODE_HOST  = 2'd2
    } irq_code_e;

    localparam int CODE_W = 2;

    // Data-word bit positions used by pending/enable writes
    localparam int WB_SSOFT  = 1;
    localparam int WB_MSOFT  = 3;
    localparam int WB_STIMER = 5;
    localparam int WB_MTIMER = 7;

    // One bit per soft/timer source
    typedef struct packed {
        logic ms;
        logic mt;
        logic ss;
        logic st;
    } src_t;

    localparam int SRC_N = 4;
    // Which src_t bits software may write as pending (ms, ss, st)
    localparam logic [SRC_N-1:0] PEND_SW_MASK = 4'b1011;
    // Index of the timer-driven pending bit within src_t
    localparam int SRC_MT_IDX = 2;

    typedef struct packed {
        logic      valid;
        irq_code_e code;
    } pick_t;

    // A level is open when running below it, or at it with interrupts enabled
    function automatic logic level_open(input logic [1:0] priv,
                                        input logic       ie,
                                        input logic [1:0] level);
        return (priv < level) || ((priv == level) && ie);
    endfunction

endpackage

// File: rtl/irq_timer_cmp.sv
`timescale 1ns/1ps
module irq_timer_cmp #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] rtc_i,
    input  logic              wr_i,
    input  logic [TIME_W-1:0] wdata_i,
    output logic [TIME_W-1:0] cmp_o,
    output logic              hit_o
);
    logic [TIME_W-1:0] cmp_q;
    logic              hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            hit_q <= 1'b0;
        end else if (wr_i) begin
            cmp_q <= wdata_i;
            hit_q <= 1'b0;
        end else if (rtc_i >= cmp_q) begin
            hit_q <= 1'b1;
        end
    end

    assign cmp_o = cmp_q;
    assign hit_o = hit_q;
endmodule

// File: rtl/irq_pend_regs.sv
`timescale 1ns/1ps
module irq_pend_regs
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_pend_i,
    input  logic wr_enab_i,
    input  src_t wdata_i,
    input  logic ipi_i,
    input  logic mtip_i,
    output src_t pend_o,
    output src_t enab_o
);
    localparam int MS_IDX = SRC_N - 1;

    logic [SRC_N-1:0] wd_v;
    logic [SRC_N-1:0] pend_v;
    logic [SRC_N-1:0] enab_v;

    assign wd_v = wdata_i;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        // enable: every source bit is software-writable
        always_ff @(posedge clk) begin
            if (rst)
                enab_v[i] <= 1'b0;
            else if (wr_enab_i)
                enab_v[i] <= wd_v[i];
        end

        if (PEND_SW_MASK[i]) begin : g_sw
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else begin
                    if (wr_pend_i)
                        bit_q <= wd_v[i];
                    if ((i == MS_IDX) && ipi_i)
                        bit_q <= 1'b1;
                end
            end
            assign pend_v[i] = bit_q;
        end else if (i == SRC_MT_IDX) begin : g_hw
            assign pend_v[i] = mtip_i;
        end else begin : g_zero
            assign pend_v[i] = 1'b0;
        end
    end

    assign pend_o = src_t'(pend_v);
    assign enab_o = src_t'(enab_v);
endmodule

// File: rtl/irq_priority_pick.sv
`timescale 1ns/1ps
module irq_priority_pick
    import irq_arb_pkg::*;
(
    input  src_t        pend_i,
    input  src_t        enab_i,
    input  logic [1:0]  priv_i,
    input  logic        ie_i,
    input  logic        host_nz_i,
    output pick_t       pick_o
);
    src_t active;
    logic m_open;
    logic s_open;

    assign active = src_t'(pend_i & enab_i);
    assign m_open = level_open(priv_i, ie_i, PRIV_MACH);
    assign s_open = level_open(priv_i, ie_i, PRIV_SUPER);

    always_comb begin
        pick_o = '{valid: 1'b0, code: CODE_SOFT};
        if (m_open && active.ms)
            pick_o = '{valid: 1'b1, code: CODE_SOFT};
        else if (m_open && active.mt)
            pick_o = '{valid: 1'b1, code: CODE_TIMER};
        else if (m_open && host_nz_i)
            pick_o = '{valid: 1'b1, code: CODE_HOST};
        else if (s_open && active.ss)
            pick_o = '{valid: 1'b1, code: CODE_SOFT};
        else if (s_open && active.st)
            pick_o = '{valid: 1'b1, code: CODE_TIMER};
    end
endmodule

// File: rtl/irq_arbiter_top.sv
`timescale 1ns/1ps
module irq_arbiter_top
    import irq_arb_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] rtc_i,
    input  logic [1:0]        priv_i,
    input  logic              ie_i,
    input  logic              wr_pend_i,
    input  logic              wr_enab_i,
    input  logic              wr_cmp_i,
    input  logic [XLEN-1:0]   wr_data_i,
    input  logic              ipi_i,
    input  logic              host_nz_i,
    output logic              take_o,
    output logic [XLEN-1:0]   cause_o
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    src_t              wd_src;
    src_t              pend_q;
    src_t              enab_q;
    logic              mtip;
    logic [TIME_W-1:0] cmp_q;
    pick_t             pick;

    assign wd_src = '{ms: wr_data_i[WB_MSOFT],
                      mt: wr_data_i[WB_MTIMER],
                      ss: wr_data_i[WB_SSOFT],
                      st: wr_data_i[WB_STIMER]};

    irq_timer_cmp #(.TIME_W(TIME_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .rtc_i   (rtc_i),
        .wr_i    (wr_cmp_i),
        .wdata_i (wr_data_i[TIME_W-1:0]),
        .cmp_o   (cmp_q),
        .hit_o   (mtip)
    );

    irq_pend_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_pend_i (wr_pend_i),
        .wr_enab_i (wr_enab_i),
        .wdata_i   (wd_src),
        .ipi_i     (ipi_i),
        .mtip_i    (mtip),
        .pend_o    (pend_q),
        .enab_o    (enab_q)
    );

    irq_priority_pick u_pick (
        .pend_i    (pend_q),
        .enab_i    (enab_q),
        .priv_i    (priv_i),
        .ie_i      (ie_i),
        .host_nz_i (host_nz_i),
        .pick_o    (pick)
    );

    assign take_o  = pick.valid;
    assign cause_o = pick.valid ? {1'b1, {PAD_W{1'b0}}, pick.code} : '0;
endmodule

// File: rtl/irq_arbiter_chk.sv
`timescale 1ns/1ps
module irq_arbiter_chk #(
    parameter int XLEN   = 64,
    parameter int TIME_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [TIME_W-1:0] rtc_i,
    input logic [TIME_W-1:0] cmp_q,
    input logic [1:0]        priv_i,
    input logic              ie_i,
    input logic              wr_cmp_i,
    input logic              ipi_i,
    input logic              host_nz_i,
    input logic [3:0]        pend_v,
    input logic [3:0]        enab_v,
    input logic              take_o,
    input logic [XLEN-1:0]   cause_o
);
    // R11: cause word flag bit and code range
    a_r11_cause_flag: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (cause_o[XLEN-1] && (cause_o[1:0] != 2'd3)));

    // R2, R3: machine mode with interrupts disabled opens no level
    a_r2_mach_closed: assert property (@(posedge clk) disable iff (rst)
        ((priv_i == 2'd3) && !ie_i) |-> !take_o);

    // R6: nothing active and no host message means no take
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        (((pend_v & enab_v) == 4'd0) && !host_nz_i) |-> !take_o);

    // R8: a compare write clears timer-pending on that edge
    a_r8_cmp_clears: assert property (@(posedge clk) disable iff (rst)
        wr_cmp_i |=> !pend_v[2]);

    // R7: count at or past compare sets timer-pending
    a_r7_timer_sets: assert property (@(posedge clk) disable iff (rst)
        (!wr_cmp_i && (rtc_i >= cmp_q)) |=> pend_v[2]);

    // R12: inter-processor strobe sets machine soft-pending
    a_r12_ipi_sets: assert property (@(posedge clk) disable iff (rst)
        ipi_i |=> pend_v[3]);
endmodule

bind irq_arbiter_top irq_arbiter_chk #(.XLEN(XLEN), .TIME_W(TIME_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rtc_i     (rtc_i),
    .cmp_q     (cmp_q),
    .priv_i    (priv_i),
    .ie_i      (ie_i),
    .wr_cmp_i  (wr_cmp_i),
    .ipi_i     (ipi_i),
    .host_nz_i (host_nz_i),
    .pend_v    (pend_q),
    .enab_v    (enab_q),
    .take_o    (take_o),
    .cause_o   (cause_o)
);

// File: tb/irq_arbiter_top_test.sv
`timescale 1ns/1ps
module irq_arbiter_top_test;
    localparam int XLEN   = 64;
    localparam int TIME_W = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [TIME_W-1:0] rtc = '0;
    logic [1:0]        priv = 2'd3;
    logic              ie = 1'b0;
    logic              wp = 1'b0, we = 1'b0, wc = 1'b0;
    logic [XLEN-1:0]   wd = '0;
    logic              ipi = 1'b0, host = 1'b0;
    logic              take;
    logic [XLEN-1:0]   cause;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;
    string phase   = "R1";

    // reference state
    bit m_ss, m_ms, m_st, m_mt;
    bit e_ss, e_ms, e_st, e_mt;
    logic [TIME_W-1:0] m_cmp;

    always #4 clk = ~clk;   // 125 MHz

    irq_arbiter_top #(.XLEN(XLEN), .TIME_W(TIME_W)) uut (
        .clk(clk), .rst(rst), .rtc_i(rtc), .priv_i(priv), .ie_i(ie),
        .wr_pend_i(wp), .wr_enab_i(we), .wr_cmp_i(wc), .wr_data_i(wd),
        .ipi_i(ipi), .host_nz_i(host), .take_o(take), .cause_o(cause)
    );

    task automatic model_edge();
        if (rst) begin
            {m_ss, m_ms, m_st, m_mt} = '0;
            {e_ss, e_ms, e_st, e_mt} = '0;
            m_cmp = '1;
        end else begin
            if (wc) begin
                m_mt  = 0;
                m_cmp = wd[TIME_W-1:0];
            end else if (rtc >= m_cmp) begin
                m_mt = 1;
            end
            if (wp) begin
                m_ss = wd[1]; m_ms = wd[3]; m_st = wd[5];
            end
            if (ipi) m_ms = 1;
            if (we) begin
                e_ss = wd[1]; e_ms = wd[3]; e_st = wd[5]; e_mt = wd[7];
            end
        end
    endtask

    task automatic expect_out(output logic t, output logic [XLEN-1:0] c);
        bit mo, so;
        int code;
        mo = (priv < 3) || (priv == 3 && ie);
        so = (priv < 1) || (priv == 1 && ie);
        t = 1; code = 0;
        if      (mo && m_ms && e_ms) code = 0;
        else if (mo && m_mt && e_mt) code = 1;
        else if (mo && host)         code = 2;
        else if (so && m_ss && e_ss) code = 0;
        else if (so && m_st && e_st) code = 1;
        else t = 0;
        c = t ? ((64'd1 << (XLEN-1)) | 64'(code)) : '0;
    endtask

    // one clock: update model at the edge, compare at the falling edge
    task automatic cycle();
        logic et;
        logic [XLEN-1:0] ec;
        @(posedge clk);
        model_edge();
        cycles++;
        #4;
        if (!rst) begin
            expect_out(et, ec);
            compared++;
            if (take !== et || cause !== ec) begin
                mismatched++;
                $display("FAIL %s cyc=%0d take=%0b cause=%h expected take=%0b cause=%h",
                         phase, cycles, take, cause, et, ec);
            end
        end
    endtask

    task automatic idle_in();
        wp = 0; we = 0; wc = 0; ipi = 0; wd = '0;
    endtask

    task automatic wr(input int kind, input logic [XLEN-1:0] data);
        idle_in();
        wd = data;
        case (kind)
            0: wp = 1;
            1: we = 1;
            default: wc = 1;
        endcase
        cycle();
        idle_in();
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        repeat (3) cycle();
        rst = 0;
        priv = 3; ie = 1;
        repeat (2) cycle();
        priv = 0; cycle();

        // R10 / R9: enable everything, write only the ignored timer bit
        phase = "R10";
        wr(1, 64'hAA);
        phase = "R9";
        wr(0, 64'h80);
        cycle();

        // R4: all machine and supervisor soft/timer pending, user mode
        phase = "R4";
        wr(0, 64'h2A);
        cycle();
        host = 1; cycle();
        wr(0, 64'h22);                // drop machine soft -> supervisor soft? no: host first
        cycle();
        // R5: supervisor only
        phase = "R5";
        host = 0; cycle();
        wr(0, 64'h20); cycle();

        // R2: machine privilege gating
        phase = "R2";
        wr(0, 64'h08);
        priv = 3; ie = 0; cycle();
        ie = 1; cycle();
        priv = 1; ie = 0; cycle();
        // R3: supervisor gating with supervisor sources only
        phase = "R3";
        wr(0, 64'h22);
        priv = 1; ie = 0; cycle();
        ie = 1; cycle();
        priv = 3; cycle();
        priv = 0; ie = 0; cycle();

        // R6: pending without enable
        phase = "R6";
        wr(1, 64'h00); cycle();
        host = 1; cycle(); host = 0; cycle();
        wr(1, 64'hAA);

        // R7: timer reaches compare
        phase = "R7";
        wr(0, 64'h00);
        wr(2, 64'd100);
        priv = 3; ie = 1;
        rtc = 98; cycle(); rtc = 99; cycle();
        rtc = 100; cycle(); cycle();
        rtc = 5; cycle();              // sticky

        // R8: compare write clears, then re-evaluates
        phase = "R8";
        rtc = 150;
        wr(2, 64'd200); cycle();
        wr(2, 64'd10);                 // already past new value
        cycle(); cycle();

        // R11: cause encodings
        phase = "R11";
        host = 1; wr(2, 64'd1000); cycle();
        host = 0; cycle();

        // R12: ipi versus clearing pending write
        phase = "R12";
        idle_in(); wp = 1; wd = 64'h00; ipi = 1; cycle(); idle_in();
        cycle();
        wr(0, 64'h00); cycle();
        ipi = 1; cycle(); ipi = 0; cycle();

        // randomized mix of all requirements
        phase = "R4_R7_R12_random";
        for (int i = 0; i < 6000; i++) begin
            idle_in();
            priv = 2'($urandom_range(0, 3));
            ie   = 1'($urandom_range(0, 1));
            host = ($urandom_range(0, 7) == 0);
            ipi  = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 3) == 0) rtc = rtc + 64'($urandom_range(0, 3));
            case ($urandom_range(0, 9))
                0: begin wp = 1; wd = {32'($urandom), 32'($urandom)}; end
                1: begin we = 1; wd = {32'($urandom), 32'($urandom)}; end
                2: begin wc = 1; wd = rtc + 64'($urandom_range(0, 6)) - 64'd3; end
                default: ;
            endcase
            cycle();
        end
        idle_in();
        cycle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        mismatched++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule